// File: doc/BRIEF.md
# Seeded Pseudo-Random Word Generator Peripheral

This block is a polled random-word source that sits on a simple synchronous 32-bit register bus. Software first loads five seed words; each seed write is mixed into a 32-bit xorshift state, and the block records which seed slots have been written. Once every slot has been written at least once, software writes a control word that selects the generator engine and requests a start. The block then produces five 32-bit output words, one per clock, and sets a completion flag in its status register. Software polls status and reads the words back.

The control register keeps the word that was written except for the start request, which always reads back as zero. The status register combines flags driven by hardware (buffer ready, seeds complete, busy, done) with a small group of bits that software may overwrite. Reads return data in the same cycle as the read strobe. Unmapped offsets read as zero and ignore writes.

Top module: `seeded_rng_periph`

## Requirements
- R1: After reset, control reads 0x00000000, status reads 0x00000001 (bit 0, buffer ready, is 1), and the five output words at 0x160, 0x164, 0x168, 0x16C and 0x170 read 0.
- R2: Seed slots at 0x140 + 4·n (n = 0..4) read as 0; writes to the output words have no effect; offsets other than control 0x000, status 0x010, the seed slots and the output words read 0 and ignore writes.
- R3: Status bit 1 is 1 only once each of the five seed slots has been written at least once; rewriting a slot does not help, and the bit stays set until reset.
- R4: A control write stores the written word with bit 4 forced to 0, whether or not a run starts.
- R5: A control write starts a run only when status bit 1 is 1, written bit 3 is 1 and written bit 4 is 1; otherwise status bits 2 and 5 and the output words do not change.
- R6: A started run holds status bit 2 (busy) at 1 for exactly five cycles after the control write, then clears it and sets status bit 5 (done).
- R7: Generation uses xs(x) = x ^= x<<13; x ^= x>>17; x ^= x<<5 on a 32-bit state that resets to 0x2545F491; a seed write with data d sets the state to xs(f), where f = state ^ d, or 0x2545F491 if that is 0; a run sets output word k (k = 0..4 in order) to the state after k+1 further steps of xs, leaving the state there.
- R8: A status write replaces status bits 5, 4 and 3 with the written bits and leaves every other status bit as it was.
- R9: A control write during a run is stored (bit 4 forced to 0) but neither restarts nor lengthens the run.
- R10: When a status write lands in the same cycle as a run completes, bit 5 reads 1 afterwards; bits 4 and 3 still take the written values.
- R11: Status bits 7, 4 and 3 are never set by hardware.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 9 | Byte offset into the 0x200-byte register window |
| bus_we | input | 1 | Write strobe, captured at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_re, 0 otherwise |

## Verification
The completion of a run and a software write to the status register can both update the done flag at the same clock edge. The bench counts cycles from the starting control write and places a status write clearing the writable group exactly on the fifth edge after it, then reads status to confirm the done flag survived while the two software-only bits took the written zeros. A restart request placed in the middle of a run is judged the same way, by the busy window still closing on the fifth edge and the output words matching a single run.

// File: rtl/rng_periph_pkg.sv
package rng_periph_pkg;
  localparam int unsigned WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  localparam int unsigned OFF_CTRL = 'h000;
  localparam int unsigned OFF_STAT = 'h010;
  localparam int unsigned OFF_SEED = 'h140;
  localparam int unsigned OFF_OUT  = 'h160;

  localparam int unsigned CTRL_ENGINE = 3;
  localparam int unsigned CTRL_START  = 4;

  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_SEEDED = 1;
  localparam int unsigned ST_BUSY  = 2;
  localparam int unsigned ST_SW_LO = 3;
  localparam int unsigned ST_SW_HI = 4;
  localparam int unsigned ST_DONE  = 5;

  localparam word_t STATE_INIT = 32'h2545_F491;

  function automatic word_t xs_step(input word_t x);
    word_t y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction
endpackage

// File: rtl/rng_seed_track.sv
module rng_seed_track #(
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_we,
  input  logic [IDX_W-1:0] seed_idx,
  output logic             all_seeded
);
  logic [NUM_WORDS-1:0] track_q;
  logic [NUM_WORDS-1:0] track_d;

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_slot
    always_comb begin
      track_d[g] = track_q[g];
      if (seed_we && (seed_idx == IDX_W'(g))) track_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) track_q <= '0;
    else if (seed_we) track_q <= track_d;
  end

  assign all_seeded = &track_q;
endmodule

// File: rtl/rng_gen_core.sv
module rng_gen_core
  import rng_periph_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5,
  localparam int unsigned IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fold_we,
  input  word_t                       fold_data,
  input  logic                        start,
  output logic                        busy,
  output logic                        finish,
  output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_WORDS - 1);

  word_t            state_q, state_d;
  logic             busy_q, busy_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             state_en;
  word_t            mixed;
  word_t            stepped;
  logic [NUM_WORDS-1:0][WORD_W-1:0] words_q;

  assign stepped = xs_step(state_q);
  assign finish  = busy_q && (idx_q == LAST_IDX);

  always_comb begin
    mixed = state_q ^ fold_data;
    if (mixed == '0) mixed = STATE_INIT;
  end

  always_comb begin
    state_d  = state_q;
    state_en = 1'b0;
    busy_d   = busy_q;
    idx_d    = idx_q;
    if (busy_q) begin
      state_d  = stepped;
      state_en = 1'b1;
      idx_d    = idx_q + 1'b1;
      if (finish) begin
        busy_d = 1'b0;
        idx_d  = '0;
      end
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (fold_we) begin
      state_d  = xs_step(mixed);
      state_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= STATE_INIT;
    else if (state_en) state_q <= state_d;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    logic load;
    assign load = busy_q && (idx_q == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) words_q[g] <= '0;
      else if (load) words_q[g] <= stepped;
    end
  end

  assign busy  = busy_q;
  assign words = words_q;
endmodule

// File: rtl/seeded_rng_periph.sv
module seeded_rng_periph
  import rng_periph_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned ADDR_W    = 9,
  localparam int unsigned IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int unsigned SPAN     = 4 * NUM_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_re,
  output logic [31:0]       bus_rdata
);
  logic [ADDR_W-1:0] seed_off, out_off;
  logic              hit_ctrl, hit_stat, hit_seed, hit_out;
  logic [IDX_W-1:0]  seed_idx, out_idx;

  assign seed_off = bus_addr - ADDR_W'(OFF_SEED);
  assign out_off  = bus_addr - ADDR_W'(OFF_OUT);
  assign hit_ctrl = (bus_addr == ADDR_W'(OFF_CTRL));
  assign hit_stat = (bus_addr == ADDR_W'(OFF_STAT));
  assign hit_seed = (bus_addr >= ADDR_W'(OFF_SEED)) && (seed_off < ADDR_W'(SPAN))
                    && (seed_off[1:0] == 2'b00);
  assign hit_out  = (bus_addr >= ADDR_W'(OFF_OUT)) && (out_off < ADDR_W'(SPAN))
                    && (out_off[1:0] == 2'b00);
  assign seed_idx = seed_off[2 +: IDX_W];
  assign out_idx  = out_off[2 +: IDX_W];

  logic ctrl_we, stat_we, seed_we;
  assign ctrl_we = bus_we && hit_ctrl;
  assign stat_we = bus_we && hit_stat;
  assign seed_we = bus_we && hit_seed;

  logic  seed_done;
  logic  gen_busy, gen_finish, gen_start;
  logic [NUM_WORDS-1:0][WORD_W-1:0] gen_words;

  rng_seed_track #(.NUM_WORDS(NUM_WORDS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .seed_we    (seed_we),
    .seed_idx   (seed_idx),
    .all_seeded (seed_done)
  );

  assign gen_start = ctrl_we && seed_done && bus_wdata[CTRL_ENGINE] && bus_wdata[CTRL_START];

  rng_gen_core #(.NUM_WORDS(NUM_WORDS)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .fold_we   (seed_we),
    .fold_data (bus_wdata),
    .start     (gen_start),
    .busy      (gen_busy),
    .finish    (gen_finish),
    .words     (gen_words)
  );

  // Control and status registers
  word_t      ctrl_q, ctrl_d;
  logic       done_q, done_d;
  logic [1:0] sw_q, sw_d;

  always_comb begin
    ctrl_d = bus_wdata;
    ctrl_d[CTRL_START] = 1'b0;
  end

  always_comb begin
    done_d = done_q;
    sw_d   = sw_q;
    if (stat_we) begin
      done_d = bus_wdata[ST_DONE];
      sw_d   = bus_wdata[ST_SW_HI:ST_SW_LO];
    end
    if (gen_finish) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (ctrl_we) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      sw_q   <= '0;
    end else if (stat_we || gen_finish) begin
      done_q <= done_d;
      sw_q   <= sw_d;
    end
  end

  word_t status;
  always_comb begin
    status = '0;
    status[ST_READY]          = 1'b1;
    status[ST_SEEDED]         = seed_done;
    status[ST_BUSY]           = gen_busy;
    status[ST_SW_HI:ST_SW_LO] = sw_q;
    status[ST_DONE]           = done_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      if (hit_ctrl)     bus_rdata = ctrl_q;
      else if (hit_stat) bus_rdata = status;
      else if (hit_out)  bus_rdata = gen_words[out_idx];
    end
  end
endmodule

// File: rtl/seeded_rng_periph_chk.sv
module seeded_rng_periph_chk
  import rng_periph_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 5,
  parameter int unsigned ADDR_W    = 9,
  localparam int unsigned CNT_W    = $clog2(NUM_WORDS + 2)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_re,
  input logic [31:0]       bus_rdata,
  input logic              gen_busy,
  input logic              seed_done,
  input logic              done_q
);
  logic [CNT_W-1:0] busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else if (gen_busy) busy_cnt <= busy_cnt + 1'b1;
    else busy_cnt <= '0;
  end

  logic mapped;
  assign mapped = (bus_addr == ADDR_W'(OFF_CTRL)) || (bus_addr == ADDR_W'(OFF_STAT)) ||
                  ((bus_addr >= ADDR_W'(OFF_OUT)) &&
                   (bus_addr < ADDR_W'(OFF_OUT + 4 * NUM_WORDS)) && (bus_addr[1:0] == 2'b00));

  a_r6_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CNT_W'(NUM_WORDS));
  a_r6_busy_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_busy) |-> busy_cnt == CNT_W'(NUM_WORDS));
  a_r10_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gen_busy) |-> done_q);
  a_r5_seed_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gen_busy) |-> seed_done);
  a_r3_seed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    seed_done |=> seed_done);
  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !mapped) |-> bus_rdata == '0);
  a_r4_start_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(OFF_CTRL)) |-> !bus_rdata[CTRL_START]);
endmodule

bind seeded_rng_periph seeded_rng_periph_chk #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_re    (bus_re),
  .bus_rdata (bus_rdata),
  .gen_busy  (gen_busy),
  .seed_done (seed_done),
  .done_q    (done_q)
);

// File: tb/seeded_rng_periph_bench.sv
module seeded_rng_periph_bench;
  localparam logic [31:0] INIT = 32'h2545_F491;

  logic        clk;
  logic        rst_n;
  logic [8:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_re;
  logic [31:0] bus_rdata;

  int n_run;
  int n_fail;

  logic [31:0] m_state;
  logic [31:0] m_out [5];

  seeded_rng_periph u_seeded_rng_periph (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    bus_re = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic seed(input int n, input logic [31:0] d);
    logic [31:0] f;
    wr(9'h140 + 9'(4 * n), d);
    f = m_state ^ d;
    if (f == 0) f = INIT;
    m_state = xs(f);
  endtask

  task automatic model_run();
    for (int k = 0; k < 5; k++) begin
      m_state = xs(m_state);
      m_out[k] = m_state;
    end
  endtask

  task automatic chk_outputs(input string req);
    for (int k = 0; k < 5; k++) rd_chk(req, 9'h160 + 9'(4 * k), m_out[k]);
  endtask

  task automatic t_reset();
    rd_chk("R1 ctrl", 9'h000, 32'h0);
    rd_chk("R1 status", 9'h010, 32'h1);
    for (int k = 0; k < 5; k++) m_out[k] = 32'h0;
    chk_outputs("R1 outputs");
  endtask

  task automatic t_partial_seed();
    seed(0, 32'h1111_0000);
    seed(1, 32'h0000_2222);
    seed(2, 32'hDEAD_BEEF);
    seed(2, 32'h0BAD_F00D);
    seed(3, 32'h1234_5678);
    rd_chk("R3 not all seeded", 9'h010, 32'h1);
    rd_chk("R2 seed reads zero", 9'h144, 32'h0);
    wr(9'h000, 32'h0000_0018);
    rd_chk("R5 no run unseeded", 9'h010, 32'h1);
    rd_chk("R4 ctrl start cleared", 9'h000, 32'h0000_0008);
    chk_outputs("R5 outputs untouched");
  endtask

  task automatic t_map();
    rd_chk("R2 unmapped 0x004", 9'h004, 32'h0);
    rd_chk("R2 unmapped 0x1FC", 9'h1FC, 32'h0);
    wr(9'h164, 32'hFFFF_FFFF);
    rd_chk("R2 output not writable", 9'h164, 32'h0);
    wr(9'h020, 32'hFFFF_FFFF);
    rd_chk("R2 unmapped write ignored status", 9'h010, 32'h1);
    rd_chk("R2 unmapped write ignored ctrl", 9'h000, 32'h0000_0008);
  endtask

  task automatic t_full_seed();
    seed(4, 32'h0000_0000);
    rd_chk("R3 all seeded", 9'h010, 32'h3);
    wr(9'h000, 32'h0000_0010);
    rd_chk("R5 no engine select", 9'h010, 32'h3);
    wr(9'h000, 32'h0000_0008);
    rd_chk("R5 no start bit", 9'h010, 32'h3);
    chk_outputs("R5 outputs still zero");
  endtask

  task automatic t_run();
    logic [31:0] v;
    wr(9'h000, 32'h0000_00F8);
    model_run();
    for (int k = 1; k <= 5; k++) begin
      rd(9'h010, v);
      chk("R6 busy window", v & 32'h24, 32'h04);
    end
    rd_chk("R6 R11 status after run", 9'h010, 32'h23);
    rd_chk("R4 ctrl after run", 9'h000, 32'h0000_00E8);
    chk_outputs("R7 output words");
  endtask

  task automatic t_status_mask();
    wr(9'h010, 32'hFFFF_FF00);
    rd_chk("R8 clear group", 9'h010, 32'h03);
    wr(9'h010, 32'h0000_0018);
    rd_chk("R8 set sw bits", 9'h010, 32'h1B);
    wr(9'h010, 32'hFFFF_FFFF);
    rd_chk("R8 R11 all ones", 9'h010, 32'h3B);
    wr(9'h010, 32'h0000_0000);
    rd_chk("R8 back to clear", 9'h010, 32'h03);
  endtask

  task automatic t_restart_busy();
    logic [31:0] v;
    wr(9'h000, 32'h0000_0018);
    model_run();
    rd(9'h010, v);
    chk("R9 busy k1", v & 32'h4, 32'h4);
    wr(9'h000, 32'h0000_0058);
    rd(9'h010, v);
    chk("R9 busy k3", v & 32'h4, 32'h4);
    rd(9'h010, v);
    chk("R9 busy k4", v & 32'h4, 32'h4);
    rd(9'h010, v);
    chk("R9 busy k5", v & 32'h4, 32'h4);
    rd(9'h010, v);
    chk("R9 run not lengthened", v, 32'h23);
    rd_chk("R9 ctrl stored", 9'h000, 32'h0000_0048);
    chk_outputs("R9 R7 single run outputs");
  endtask

  task automatic t_collide();
    wr(9'h010, 32'h0);
    wr(9'h000, 32'h0000_0018);
    model_run();
    repeat (4) @(negedge clk);
    wr(9'h010, 32'h0000_0000);
    rd_chk("R10 done wins collision", 9'h010, 32'h23);
    chk_outputs("R10 R7 outputs");
    wr(9'h010, 32'h0000_0018);
    rd_chk("R10 later write applies", 9'h010, 32'h1B);
  endtask

  initial begin
    n_run = 0; n_fail = 0;
    m_state = INIT;
    bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; bus_re = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial_seed();
    t_map();
    t_full_seed();
    t_run();
    t_status_mask();
    t_restart_busy();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule